// File: doc/BRIEF.md
# Symmetric Polyphase Decimating Lowpass Filter

This block is the first filtering stage for one real channel (the in-phase or the quadrature path) after a digital mixer. It suppresses the sum-frequency image left by mixing and lowers the sample rate by a factor N that software picks at run time from the multiples of four (4, 8, 12, ...). The filter is a linear-phase FIR with an even tap count. Its impulse response is mirror-symmetric, so only half of the coefficients are stored. They sit in a small on-chip coefficient memory that can be rewritten while the filter runs.

Incoming samples move through a history line at the input rate. The multiply-accumulate work is done only once per N accepted samples. On that cycle each mirrored pair of history samples is added first and then multiplied by its shared coefficient, so the datapath has half as many multipliers as taps and they are used at the output rate. The full-growth sum is rounded half-up to the output width and saturated.

A two-state controller sequences the block. It stays in `ST_GATHER` while it counts accepted samples. On the input that completes a group it moves `ST_GATHER -> ST_FIRE`. It spends exactly one cycle in `ST_FIRE`, in which the result is formed, and then returns `ST_FIRE -> ST_GATHER`. A synchronous clear (or reset) forces `ST_GATHER` from either state.

Top module: `symdec_fir`

## Requirements
- R1: Exactly one `out_valid` pulse, one cycle wide, is produced for every N accepted inputs (an accepted input has `in_valid` high at a rising edge). N = 4*`dec_mult`, and `dec_mult` = 0 is treated as 1. After reset, and before any clear, N is 4.
- R2: Counting accepted inputs from the last clear as x[0], x[1], ..., and taking samples before x[0] as zero, each output is the k-th kept sample y[kN-1], with y[n] = sum over j of h[j]*x[n-j] for j = 0..NTAPS-1. The mirrored taps h[j] and h[NTAPS-1-j] are both the value stored at coefficient address j, for j < NTAPS/2.
- R3: If the input that completes a group is accepted at rising edge k, then `out_valid` is high from edge k+1 to edge k+2, and `out_data` holds the result during that interval.
- R4: A new `dec_mult` value is taken only at a clear or at the edge that accepts the last input of a group. It then sets N for the following group, so a group is never cut short or stretched.
- R5: The full-precision sum is rounded by adding 2^(SHIFT-1) and arithmetic-shifting right by SHIFT. With SHIFT = 10, a sum of 512 gives 1, a sum of -512 gives 0 and a sum of -513 gives -1.
- R6: A rounded value outside the signed OUT_W range is clamped to 2^(OUT_W-1)-1 or to -2^(OUT_W-1).
- R7: A high `clr` at a rising edge empties the history (all zero) and resets the group count to zero. It loads N from `dec_mult` and forces `out_valid` low after that edge, including when an output was due.
- R8: A coefficient write (`coef_we` high) at an edge is used by every output computed after that edge.
- R9: After reset, `out_valid` and `out_data` are zero.
- R10: A cycle with `in_valid` low neither shifts the history nor advances the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of history and phase |
| dec_mult | input | DEC_W | Decimation factor divided by four (0 means 1) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | CA_W | Coefficient address (pair index) |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Signed rounded and saturated output |

## Verification
The assertions rely on `dec_mult` yielding N of at least four, so a group can never complete while the controller is in `ST_FIRE`. They also rely on `clr` being the only event other than group completion that may change the held factor. The stimulus keeps `dec_mult` within its declared width and changes it freely between and inside groups. It inserts random gaps in `in_valid` and asserts `clr` both between groups and on the cycle an output is due. The reference model latches the factor under the same rule as the requirement, so outputs from mid-group factor changes are predicted exactly.

// File: rtl/symdec_pkg.sv
package symdec_pkg;
    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_FIRE   = 1'b1
    } symdec_state_e;
endpackage

// File: rtl/symdec_ctrl.sv
module symdec_ctrl
    import symdec_pkg::*;
#(
    parameter int DEC_W = 3,
    localparam int PH_W = DEC_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [DEC_W-1:0] dec_mult,
    output logic             fire,
    output logic [PH_W-1:0]  phase,
    output logic [PH_W-1:0]  lim
);
    symdec_state_e state, nxt;
    logic [PH_W-1:0] req_lim;
    logic            group_done;

    // Requested group length: four times the multiplier, zero read as one.
    assign req_lim    = (dec_mult == '0) ? PH_W'(4) : {dec_mult, 2'b00};
    assign group_done = in_valid && (phase == PH_W'(lim - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || clr) state <= ST_GATHER;
        else            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_GATHER: nxt = group_done ? ST_FIRE : ST_GATHER;
            ST_FIRE:   nxt = group_done ? ST_FIRE : ST_GATHER;
            default:   nxt = ST_GATHER;
        endcase
    end

    assign fire = (state == ST_FIRE);

    // Phase counter and held factor; the factor moves only at group boundaries.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            lim   <= PH_W'(4);
        end else if (clr || group_done) begin
            phase <= '0;
            lim   <= req_lim;
        end else if (in_valid) begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/symdec_hist.sv
module symdec_hist #(
    parameter int IN_W  = 12,
    parameter int NTAPS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic signed [IN_W-1:0] taps [NTAPS]
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
        end else if (in_valid) begin
            taps[0] <= in_data;
            for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
        end
    end
endmodule

// File: rtl/symdec_coef_ram.sv
module symdec_coef_ram #(
    parameter int COEF_W = 12,
    parameter int HALF   = 4,
    localparam int CA_W  = $clog2(HALF)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [CA_W-1:0]          addr,
    input  logic signed [COEF_W-1:0] wdata,
    output logic signed [COEF_W-1:0] coefs [HALF]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF; i++) coefs[i] <= '0;
        end else if (we) begin
            coefs[addr] <= wdata;
        end
    end
endmodule

// File: rtl/symdec_mac.sv
module symdec_mac #(
    parameter int IN_W   = 12,
    parameter int COEF_W = 12,
    parameter int NTAPS  = 8,
    parameter int OUT_W  = 14,
    parameter int SHIFT  = 10,
    localparam int HALF  = NTAPS / 2,
    localparam int ACC_W = IN_W + 1 + COEF_W + $clog2(HALF)
) (
    input  logic signed [IN_W-1:0]   taps  [NTAPS],
    input  logic signed [COEF_W-1:0] coefs [HALF],
    output logic signed [OUT_W-1:0]  y
);
    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((2 ** (OUT_W-1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - 1;
    localparam logic signed [ACC_W:0] BIAS   = (ACC_W+1)'(2 ** (SHIFT-1));

    logic signed [IN_W:0]    pre  [HALF];
    logic signed [ACC_W-1:0] prod [HALF];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W:0]   biased, shifted;

    // One pre-add and one multiply per mirrored pair.
    for (genvar j = 0; j < HALF; j++) begin : g_pair
        assign pre[j]  = {taps[j][IN_W-1], taps[j]} + {taps[NTAPS-1-j][IN_W-1], taps[NTAPS-1-j]};
        assign prod[j] = pre[j] * coefs[j];
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < HALF; j++) acc = acc + prod[j];
        biased  = {acc[ACC_W-1], acc} + BIAS;
        shifted = biased >>> SHIFT;
        if (shifted > SAT_HI)      y = SAT_HI[OUT_W-1:0];
        else if (shifted < SAT_LO) y = SAT_LO[OUT_W-1:0];
        else                       y = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/symdec_fir.sv
module symdec_fir #(
    parameter int IN_W   = 12,
    parameter int COEF_W = 12,
    parameter int NTAPS  = 8,
    parameter int OUT_W  = 14,
    parameter int SHIFT  = 10,
    parameter int DEC_W  = 3,
    localparam int HALF  = NTAPS / 2,
    localparam int CA_W  = $clog2(HALF),
    localparam int PH_W  = DEC_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic [DEC_W-1:0]         dec_mult,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_data,
    input  logic                     coef_we,
    input  logic [CA_W-1:0]          coef_addr,
    input  logic signed [COEF_W-1:0] coef_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    logic                     fire;
    logic [PH_W-1:0]          phase, lim;
    logic signed [IN_W-1:0]   taps  [NTAPS];
    logic signed [COEF_W-1:0] coefs [HALF];
    logic signed [OUT_W-1:0]  y;

    symdec_ctrl #(.DEC_W(DEC_W)) u_ctrl (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .dec_mult(dec_mult), .fire(fire), .phase(phase), .lim(lim)
    );

    symdec_hist #(.IN_W(IN_W), .NTAPS(NTAPS)) u_hist (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .taps(taps)
    );

    symdec_coef_ram #(.COEF_W(COEF_W), .HALF(HALF)) u_coef (
        .clk(clk), .rst(rst), .we(coef_we), .addr(coef_addr),
        .wdata(coef_data), .coefs(coefs)
    );

    symdec_mac #(
        .IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS),
        .OUT_W(OUT_W), .SHIFT(SHIFT)
    ) u_mac (
        .taps(taps), .coefs(coefs), .y(y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (clr) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= fire;
            if (fire) out_data <= y;
        end
    end
endmodule

// File: rtl/symdec_fir_chk.sv
module symdec_fir_chk #(
    parameter int PH_W = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic            in_valid,
    input logic            fire,
    input logic            out_valid,
    input logic [PH_W-1:0] phase,
    input logic [PH_W-1:0] lim
);
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (rst)
        phase < lim);

    assert_fire_to_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && !clr) |=> out_valid);

    assert_valid_from_fire_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(fire));

    assert_factor_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(in_valid && phase == PH_W'(lim - 1'b1))) |=> $stable(lim));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!out_valid && phase == '0));

    assert_gap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr && !in_valid) |=> $stable(phase));
endmodule

bind symdec_fir symdec_fir_chk #(.PH_W(DEC_W + 2)) u_chk (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .fire(fire),
    .out_valid(out_valid), .phase(phase), .lim(lim)
);

// File: tb/symdec_fir_tb.sv
`timescale 1ns/1ps
module symdec_fir_tb;
    localparam int IN_W = 12, COEF_W = 12, NTAPS = 8, OUT_W = 14, SHIFT = 10, DEC_W = 3;
    localparam int HALF = NTAPS / 2;
    localparam int CA_W = $clog2(HALF);

    logic clk = 1'b0, rst = 1'b1, clr = 1'b0, in_valid = 1'b0, coef_we = 1'b0;
    logic [DEC_W-1:0] dec_mult = '0;
    logic signed [IN_W-1:0] in_data = '0;
    logic [CA_W-1:0] coef_addr = '0;
    logic signed [COEF_W-1:0] coef_data = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    symdec_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .OUT_W(OUT_W),
                 .SHIFT(SHIFT), .DEC_W(DEC_W)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .dec_mult(dec_mult), .in_valid(in_valid),
        .in_data(in_data), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0, mon_on = 0;
    int hc [HALF];
    int bx [NTAPS];
    int m_phase = 0, m_lim = 4;
    int qv[$], qd[$];
    string qt[$];
    string cur_tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lim_of(int m);
        return (m == 0) ? 4 : 4 * m;
    endfunction

    function automatic int ref_out();
        longint acc = 0;
        longint r;
        longint hi = (64'sd1 <<< (OUT_W - 1)) - 1;
        for (int j = 0; j < HALF; j++) acc += longint'(bx[j] + bx[NTAPS-1-j]) * hc[j];
        r = (acc + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
        if (r > hi) r = hi;
        if (r < -hi - 1) r = -hi - 1;
        return int'(r);
    endfunction

    task automatic send(int x, bit v, int m);
        in_valid = v; in_data = IN_W'(x); dec_mult = DEC_W'(m);
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (v) begin
            for (int i = NTAPS - 1; i > 0; i--) bx[i] = bx[i-1];
            bx[0] = x;
            m_phase++;
            if (m_phase == m_lim) begin
                m_phase = 0;
                m_lim = lim_of(m);
                qv.push_back(ref_out()); qd.push_back(cyc + 1); qt.push_back(cur_tag);
            end
        end
    endtask

    task automatic wcoef(int a, int v);
        coef_we = 1'b1; coef_addr = CA_W'(a); coef_data = COEF_W'(v);
        @(posedge clk); #1;
        coef_we = 1'b0;
        hc[a] = v;
    endtask

    task automatic do_clear(int m, bit drain);
        if (drain) begin send(0, 0, m); send(0, 0, m); end
        dec_mult = DEC_W'(m); clr = 1'b1;
        @(posedge clk); #1;
        clr = 1'b0;
        // An output due at this edge is suppressed by the clear (R7).
        while (qd.size() > 0 && qd[$] >= cyc) begin
            void'(qv.pop_back()); void'(qd.pop_back()); void'(qt.pop_back());
        end
        m_phase = 0; m_lim = lim_of(m);
        for (int i = 0; i < NTAPS; i++) bx[i] = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after clear", int'(out_valid), 0);
        @(posedge clk); #1;
    endtask

    // Output monitor: timing (R3) and value against the reference model.
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (qd.size() > 0 && qd[0] == cyc) begin
                chk(out_valid == 1'b1, {qt[0], " R3 out_valid on due cycle"}, int'(out_valid), 1);
                chk(int'(out_data) == qv[0], {qt[0], " output value"}, int'(out_data), qv[0]);
                void'(qv.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
            end else if (out_valid) begin
                chk(1'b0, "R1 unexpected out_valid", 1, 0);
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < HALF; i++) hc[i] = 0;
        for (int i = 0; i < NTAPS; i++) bx[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(out_data == '0, "R9 reset out_data", int'(out_data), 0);
        mon_on = 1;

        // R2: impulse response, N = 4
        wcoef(0, 3); wcoef(1, -7); wcoef(2, 20); wcoef(3, 60);
        do_clear(1, 1);
        cur_tag = "R2";
        send(1024, 1, 1);
        for (int i = 0; i < 11; i++) send(0, 1, 1);

        // R5: rounding of sums 512, -512, -513
        wcoef(0, 1); wcoef(1, 0); wcoef(2, 0); wcoef(3, 0);
        do_clear(1, 1);
        cur_tag = "R5";
        send(0, 1, 1); send(0, 1, 1); send(0, 1, 1); send(512, 1, 1);
        send(0, 1, 1); send(0, 1, 1); send(0, 1, 1); send(-512, 1, 1);
        send(0, 1, 1); send(0, 1, 1); send(0, 1, 1); send(-513, 1, 1);
        send(0, 0, 1); send(0, 0, 1);
        chk(qv.size() == 0, "R5 all rounding outputs seen", qv.size(), 0);

        // R6: saturation both ways
        for (int j = 0; j < HALF; j++) wcoef(j, -2048);
        do_clear(1, 1);
        cur_tag = "R6";
        for (int i = 0; i < 8; i++) send(-2048, 1, 1);
        for (int i = 0; i < 8; i++) send(2047, 1, 1);

        // R7: clear mid-group and clear on the cycle an output is due
        do_clear(2, 1);
        cur_tag = "R7";
        send(100, 1, 2); send(200, 1, 2); send(300, 1, 2);
        do_clear(2, 0);
        for (int i = 0; i < 8; i++) send(50 * i, 1, 2);
        do_clear(1, 0);
        for (int i = 0; i < 8; i++) send(-40 * i, 1, 1);

        // R4 / R10: random stream, gaps, factor changes anywhere
        for (int j = 0; j < HALF; j++) wcoef(j, int'($urandom_range(600)) - 300);
        do_clear(3, 1);
        cur_tag = "R4";
        begin
            int m = 3;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(40) == 0) m = $urandom_range(7);
                send(int'($urandom_range(4095)) - 2048, $urandom_range(9) < 7, m);
            end
        end
        cur_tag = "R10";
        for (int i = 0; i < 24; i++) send(333 - 29 * i, (i % 3) != 1, 1);

        // R8: coefficient rewrite mid-stream
        do_clear(1, 1);
        cur_tag = "R8";
        for (int i = 0; i < 6; i++) send(500 - 150 * i, 1, 1);
        wcoef(1, 250);
        for (int i = 0; i < 14; i++) send(-300 + 70 * i, 1, 1);

        send(0, 0, 1); send(0, 0, 1); send(0, 0, 1);
        chk(qv.size() == 0, "R1 no outputs missing", qv.size(), 0);
        done = 1;
    end

    initial begin
        while (!done && cyc < 150000) @(posedge clk);
        if (!done) chk(1'b0, "watchdog expired", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule